// File: doc/BRIEF.md
# Two-Stage SD Card Clock Generator

This block derives the card clock for an SD host from a fast reference clock. The reference is first divided by a power-of-two prescaler (2 to 256) and then by a linear divisor (1 to 16). The total ratio is therefore always even, and the output has an exact 50% duty cycle. A single 32-bit control register sets up the block. Software reaches it through a plain write strobe, a word address and a combinational read-data path. The register holds a prescaler code, a divisor code and three clock-enable bits.

The card clock runs only while all three enables are set. To change frequency, software first clears the enables and the divide field, then writes the new codes with the enables set again. The divide codes are copied into the generator only when the clock starts from a stopped state. A write that changes the codes while the clock is running has no effect on the output until the next stop and restart. When the enables drop, any high phase already under way runs to its full length. The output then rests low, so no shortened pulse ever reaches the card.

There is no data stream through this block. The bus port is a single-cycle register access with no handshake, and the card clock is a plain registered output.

Top module: `sd_clkgen_top`

## Requirements
- R1: After reset the control register reads 0x0000_0000 and `card_clk` is low.
- R2: A write with `bus_addr` equal to 0x2C stores bits [2:0] (enables), [7:4] (divisor code) and [15:8] (prescaler code); all other bits read back as zero. Writes to any other address leave the register unchanged. Reads at other addresses return zero.
- R3: `card_clk` stays low unless enable bits 0, 1 and 2 are all set.
- R4: A prescaler code with exactly one bit set, value c (0x01..0x80), gives a prescale ratio of 2*c.
- R5: A prescaler code of zero, or with more than one bit set, gives a prescale ratio of 2.
- R6: A divisor code d gives a linear ratio of d+1. The high phase and the low phase of `card_clk` each last H = (prescale/2)*(d+1) reference cycles.
- R7: After the write that sets all enables is captured at a clock edge, `card_clk` is low and first rises on the (H+1)-th following edge.
- R8: Clearing an enable while `card_clk` is high lets the high phase finish its full H cycles, after which the output stays low. Clearing it while low produces no further rising edge.
- R9: A change of the divide codes written while the clock is running does not alter the output period until the clock has stopped and been restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| card_clk | output | 1 | Divided, gated card clock (registered) |

## Verification
A register write lands at the edge that samples `bus_wr`, and its readback is visible combinationally from then on. The first rising card-clock edge is due H+1 edges later, and the high and low phases then each take H edges. The bench drives inputs and samples `card_clk` at falling edges only. It counts falling edges from the one that follows the capturing edge, and compares each count with H, which it computes from the codes it wrote. Stop behaviour is measured the same way: the bench counts the length of the last high phase and checks that the output stays low for several multiples of H afterwards.

// File: rtl/sd_clkgen_pkg.sv
package sd_clkgen_pkg;
  localparam int CTRL_W  = 32;
  localparam int EN_W    = 3;
  localparam int DIV_W   = 4;
  localparam int PRE_W   = 8;
  localparam int EN_LSB  = 0;
  localparam int DIV_LSB = 4;
  localparam int PRE_LSB = DIV_LSB + DIV_W;

  typedef struct packed {
    logic [PRE_W-1:0] pre_code;
    logic [DIV_W-1:0] div_code;
  } div_cfg_t;

  // Half of the prescale ratio; any code that is not a single set bit maps to 1.
  function automatic logic [PRE_W-1:0] pre_half(input logic [PRE_W-1:0] code);
    return $onehot(code) ? code : PRE_W'(1);
  endfunction
endpackage

// File: rtl/sd_clkgen_regs.sv
module sd_clkgen_regs
  import sd_clkgen_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CTRL_OFFSET = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  output logic [EN_W-1:0]   en_o,
  output div_cfg_t          cfg_o
);
  logic             hit;
  logic [EN_W-1:0]  en_q;
  div_cfg_t         cfg_q;
  logic             unused_wdata;

  assign hit          = (bus_addr == ADDR_W'(CTRL_OFFSET));
  assign unused_wdata = ^{bus_wdata[CTRL_W-1:PRE_LSB+PRE_W], bus_wdata[DIV_LSB-1:EN_LSB+EN_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else if (bus_wr && hit) begin
      en_q           <= bus_wdata[EN_LSB +: EN_W];
      cfg_q.div_code <= bus_wdata[DIV_LSB +: DIV_W];
      cfg_q.pre_code <= bus_wdata[PRE_LSB +: PRE_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[EN_LSB +: EN_W]   = en_q;
      bus_rdata[DIV_LSB +: DIV_W] = cfg_q.div_code;
      bus_rdata[PRE_LSB +: PRE_W] = cfg_q.pre_code;
    end
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/sd_clkgen_prescale.sv
module sd_clkgen_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] half_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == half_i - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/sd_clkgen_lindiv.sv
module sd_clkgen_lindiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] ratio_m1_i,
  output logic             flip_o
);
  logic [DIV_W-1:0] cnt_q;

  assign flip_o = tick_i && (cnt_q == ratio_m1_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (flip_o)     cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sd_clkgen_top.sv
module sd_clkgen_top
  import sd_clkgen_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CTRL_OFFSET = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              card_clk
);
  logic [EN_W-1:0] en_w;
  div_cfg_t        cfg_w;
  div_cfg_t        cfg_q;
  logic            run_w;
  logic            active_q;
  logic            card_clk_q;
  logic            tick_w;
  logic            flip_w;

  sd_clkgen_regs #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_o(en_w), .cfg_o(cfg_w)
  );

  assign run_w = &en_w;

  sd_clkgen_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(!active_q),
    .half_i(pre_half(cfg_q.pre_code)), .tick_o(tick_w)
  );

  sd_clkgen_lindiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(!active_q), .tick_i(tick_w),
    .ratio_m1_i(cfg_q.div_code), .flip_o(flip_w)
  );

  // Start from idle copies the codes; a stop request waits for the low phase.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      card_clk_q <= 1'b0;
      cfg_q      <= '0;
    end else if (!active_q) begin
      card_clk_q <= 1'b0;
      if (run_w) begin
        active_q <= 1'b1;
        cfg_q    <= cfg_w;
      end
    end else if (!run_w && !card_clk_q) begin
      active_q <= 1'b0;
    end else if (flip_w) begin
      card_clk_q <= ~card_clk_q;
      if (card_clk_q && !run_w) active_q <= 1'b0;
    end
  end

  assign card_clk = card_clk_q;
endmodule

// File: rtl/sd_clkgen_chk.sv
module sd_clkgen_chk
  import sd_clkgen_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [EN_W-1:0] en,
  input logic            active,
  input div_cfg_t        cfg_lat,
  input logic            card_clk,
  input logic [31:0]     bus_rdata
);
  // R2: reserved bits never read as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[31:16] == 16'h0) && (bus_rdata[3] == 1'b0));

  // R3: a stopped, low clock stays low while any enable is clear
  a_r3_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&en) && !card_clk) |=> !card_clk);

  // R7: the generator starts with the clock low
  a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !card_clk);

  // R8: the clock only moves while the generator was running
  a_r8_move_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(card_clk) |-> $past(active));

  // R8: the generator only stops with the clock low
  a_r8_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !card_clk);

  // R9: the working codes do not change while running
  a_r9_codes_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cfg_lat));
endmodule

bind sd_clkgen_top sd_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_w), .active(active_q),
  .cfg_lat(cfg_q), .card_clk(card_clk_q), .bus_rdata(bus_rdata)
);

// File: tb/tb_sd_clkgen_top.sv
module tb_sd_clkgen_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = 12'h02C;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        card_clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  sd_clkgen_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_clk(card_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [7:0] pc, input logic [3:0] dc);
    int p;
    p = $onehot(pc) ? int'(pc) : 1;
    return p * (int'(dc) + 1);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 12'h02C;
  endtask

  task automatic stop_and_settle();
    wr(12'h02C, 32'h0);
    repeat (300) @(negedge clk);
  endtask

  task automatic stays_low(input int cycles, input string req);
    int highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (card_clk) highs++;
    end
    check(highs == 0, req, highs, 0);
  endtask

  // Start with given codes, check first-rise delay and two full phases.
  task automatic run_measure(input logic [7:0] pc, input logic [3:0] dc, input string req);
    int h, n, k;
    h = half_of(pc, dc);
    wr(12'h02C, {16'h0, pc, dc, 4'b0111});
    n = 0;
    while (!card_clk && n < 10000) begin @(negedge clk); n++; end
    check(n == h + 1, {req, " R7 first rise"}, n, h + 1);
    k = 1;
    @(negedge clk);
    while (card_clk && k < 10000) begin k++; @(negedge clk); end
    check(k == h, {req, " R6 high phase"}, k, h);
    k = 1;
    @(negedge clk);
    while (!card_clk && k < 10000) begin k++; @(negedge clk); end
    check(k == h, {req, " R6 low phase"}, k, h);
    stop_and_settle();
  endtask

  task automatic t_reset();
    check(bus_rdata == 32'h0, "R1 reg reset", bus_rdata, 0);
    stays_low(20, "R1 clock low after reset");
  endtask

  task automatic t_regs();
    wr(12'h02C, 32'hFFFF_FFFF);
    @(negedge clk);
    check(bus_rdata == 32'h0000_FFF7, "R2 readback mask", bus_rdata, 32'h0000_FFF7);
    wr(12'h030, 32'h0);
    bus_addr = 12'h030;
    #1;
    check(bus_rdata == 32'h0, "R2 other address reads zero", bus_rdata, 0);
    bus_addr = 12'h02C;
    #1;
    check(bus_rdata == 32'h0000_FFF7, "R2 other address write ignored", bus_rdata, 32'h0000_FFF7);
    stop_and_settle();
  endtask

  task automatic t_gating();
    wr(12'h02C, 32'h0000_0103); stays_low(40, "R3 enable2 clear");
    wr(12'h02C, 32'h0000_0105); stays_low(40, "R3 enable1 clear");
    wr(12'h02C, 32'h0000_0106); stays_low(40, "R3 enable0 clear");
    stop_and_settle();
  endtask

  task automatic t_stop_high();
    int k;
    wr(12'h02C, 32'h0000_0147);           // H = 5
    while (!card_clk) @(negedge clk);
    k = 1;
    @(negedge clk); k++;
    bus_wr = 1'b1; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    if (card_clk) k++;
    while (card_clk && k < 1000) begin @(negedge clk); if (card_clk) k++; end
    check(k == 5, "R8 high phase not shortened", k, 5);
    stays_low(20, "R8 low after stop while high");
    stop_and_settle();
  endtask

  task automatic t_stop_low();
    wr(12'h02C, 32'h0000_0147);
    while (!card_clk) @(negedge clk);
    while (card_clk) @(negedge clk);
    wr(12'h02C, 32'h0);
    stays_low(20, "R8 no rise after stop while low");
    stop_and_settle();
  endtask

  task automatic t_live_change();
    int k;
    wr(12'h02C, 32'h0000_0117);           // H = 2
    while (!card_clk) @(negedge clk);
    wr(12'h02C, 32'h0000_0197);           // new code: H = 10
    check(bus_rdata == 32'h0000_0197, "R9 readback of new codes", bus_rdata, 32'h0000_0197);
    while (card_clk) @(negedge clk);
    while (!card_clk) @(negedge clk);
    k = 1;
    @(negedge clk);
    while (card_clk && k < 1000) begin k++; @(negedge clk); end
    check(k == 2, "R9 period kept while running", k, 2);
    stop_and_settle();
    run_measure(8'h01, 4'h9, "R9 new codes after restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gating();
    run_measure(8'h01, 4'h0, "R4 code 0x01");
    run_measure(8'h04, 4'h2, "R4 code 0x04");
    run_measure(8'h80, 4'h0, "R4 code 0x80");
    run_measure(8'h00, 4'h3, "R5 zero code");
    run_measure(8'h06, 4'h1, "R5 multi-bit code");
    run_measure(8'h02, 4'hF, "R6 divisor 16");
    run_measure(8'h01, 4'h6, "R6 divisor 7");
    t_stop_high();
    t_stop_low();
    t_live_change();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule